// File: doc/BRIEF.md
# Conditional Branch Resolver

This block resolves a single-word conditional branch of a 16-bit processor. It reads an instruction word, finds out whether the word is a branch, and checks the branch condition against the negative, zero, carry and overflow flags. It then works out where execution continues. The offset field counts words, so the block scales it to bytes and adds it to the address of the word that follows the instruction.

The block has a combinational resolver and a registered wrapper. On a cycle with the valid strobe high, the wrapper captures the instruction word, the sequential address and the flags. The resolved result is presented on the next cycle, together with a one-cycle result-valid pulse. Instruction fetch and flag generation are outside the block. The block never writes the flags.

Top module: `cbr_unit`

## Requirements
- R1: An instruction word is a branch only when bits 15:13 equal 3'b001. Any other word gives is_branch=0, not_branch=1 and taken=0, and next_pc equals the sequential address.
- R2: Branch bits 12:10 select the condition: 000 takes when Z=0, 001 takes when Z=1, 010 takes when C=0, and 011 takes when C=1.
- R3: Condition 100 takes when N=1, condition 101 takes when N==V, condition 110 takes when N!=V, and condition 111 always takes.
- R4: target = seq_pc + 2*sext(bits 9:0), computed modulo 2^16. Here seq_pc is the address after the instruction, and bits 9:0 are a two's-complement word offset.
- R5: When taken=1, next_pc equals target. Otherwise next_pc equals seq_pc.
- R6: Bit 0 of target and of next_pc is always 0, whatever the value of bit 0 of seq_pc.
- R7: The word 0x2FE4 resolves as condition 011 with an offset of -28 words. With C=1 it is taken to seq_pc-56, and with C=0 it is not taken.
- R8: A result appears on the cycle after an accepted strobe, with res_valid high for one cycle. Without a strobe, res_valid is 0 and the result outputs hold their values.
- R9: Reset clears res_valid, taken, is_branch and target to 0, sets not_branch to 1 and sets next_pc to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Accept strobe |
| instr | input | 16 | Instruction word |
| seq_pc | input | 16 | Address of the word following the instruction |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_v | input | 1 | Overflow flag |
| res_valid | output | 1 | Result valid pulse |
| taken | output | 1 | Branch taken |
| is_branch | output | 1 | Word was a branch |
| not_branch | output | 1 | Word was not a branch |
| target | output | 16 | Branch destination |
| next_pc | output | 16 | Next program address |

## Verification
The stimulus sweeps every condition code across all sixteen flag combinations. This separates each condition from the others, including the signed pair that compares N against V. Directed offsets of zero, +511 and -512 and the encoded word 0x2FE4 check sign extension and the scaling by two. An odd sequential address checks that bit 0 is cleared. Random words with other top-bit patterns check that non-branches fall through, and idle cycles between strobes check that the outputs hold their values.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
    parameter int unsigned PC_W   = 16;
    parameter int unsigned OFS_W  = 10;
    parameter int unsigned COND_W = 3;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    typedef enum logic [COND_W-1:0] {
        C_NE  = 3'd0,
        C_EQ  = 3'd1,
        C_NC  = 3'd2,
        C_CS  = 3'd3,
        C_NEG = 3'd4,
        C_GE  = 3'd5,
        C_LT  = 3'd6,
        C_ALW = 3'd7
    } cond_t;

    typedef struct packed {
        logic            valid;
        logic            taken;
        logic            is_br;
        logic [PC_W-1:0] target;
        logic [PC_W-1:0] next_pc;
    } res_t;
endpackage

// File: rtl/cbr_cond_eval.sv
module cbr_cond_eval
    import cbr_pkg::*;
(
    input  logic [COND_W-1:0] cond,
    input  flags_t            flg,
    output logic              pass
);
    always_comb begin
        unique case (cond_t'(cond))
            C_NE:    pass = ~flg.z;
            C_EQ:    pass = flg.z;
            C_NC:    pass = ~flg.c;
            C_CS:    pass = flg.c;
            C_NEG:   pass = flg.n;
            C_GE:    pass = ~(flg.n ^ flg.v);
            C_LT:    pass = flg.n ^ flg.v;
            default: pass = 1'b1;
        endcase
    end

    // R3
    always_comb begin
        if (cond == 3'd7) begin
            always_pass_chk: assert (pass);
        end
    end
endmodule

// File: rtl/cbr_target_calc.sv
module cbr_target_calc
    import cbr_pkg::*;
#(
    parameter int unsigned W  = PC_W,
    parameter int unsigned OW = OFS_W
) (
    input  logic [W-1:0]  seq_pc,
    input  logic [OW-1:0] ofs,
    output logic [W-1:0]  target
);
    localparam int unsigned EXT = W - OW - 1;

    logic [W-1:0] ofs_bytes;
    logic [W-1:0] base;

    always_comb begin
        ofs_bytes = {{EXT{ofs[OW-1]}}, ofs, 1'b0};
        base      = {seq_pc[W-1:1], 1'b0};
        target    = base + ofs_bytes;
    end

    // R6
    always_comb begin
        target_even_chk: assert (target[0] == 1'b0);
    end
endmodule

// File: rtl/cbr_resolve.sv
module cbr_resolve
    import cbr_pkg::*;
(
    input  logic [PC_W-1:0] instr,
    input  logic [PC_W-1:0] seq_pc,
    input  flags_t          flg,
    output logic            is_br,
    output logic            taken,
    output logic [PC_W-1:0] target,
    output logic [PC_W-1:0] next_pc
);
    localparam logic [2:0] BR_OP = 3'b001;

    logic       pass;
    logic [PC_W-1:0] seq_even;

    cbr_cond_eval u_cond (
        .cond (instr[OFS_W+COND_W-1:OFS_W]),
        .flg  (flg),
        .pass (pass)
    );

    cbr_target_calc #(.W(PC_W), .OW(OFS_W)) u_tgt (
        .seq_pc (seq_pc),
        .ofs    (instr[OFS_W-1:0]),
        .target (target)
    );

    always_comb begin
        seq_even = {seq_pc[PC_W-1:1], 1'b0};
        is_br    = (instr[PC_W-1:PC_W-3] == BR_OP);
        taken    = is_br & pass;
        next_pc  = taken ? target : seq_even;
    end

    // R1
    always_comb begin
        if (!is_br) begin
            nonbranch_not_taken_chk: assert (!taken);
        end
    end
endmodule

// File: rtl/cbr_unit.sv
module cbr_unit
    import cbr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [15:0] instr,
    input  logic [15:0] seq_pc,
    input  logic        flag_n,
    input  logic        flag_z,
    input  logic        flag_c,
    input  logic        flag_v,
    output logic        res_valid,
    output logic        taken,
    output logic        is_branch,
    output logic        not_branch,
    output logic [15:0] target,
    output logic [15:0] next_pc
);
    flags_t          flg;
    logic            c_isbr;
    logic            c_taken;
    logic [PC_W-1:0] c_target;
    logic [PC_W-1:0] c_next;
    res_t            res_d;
    res_t            res_q;

    assign flg = '{n: flag_n, z: flag_z, c: flag_c, v: flag_v};

    cbr_resolve u_res (
        .instr   (instr),
        .seq_pc  (seq_pc),
        .flg     (flg),
        .is_br   (c_isbr),
        .taken   (c_taken),
        .target  (c_target),
        .next_pc (c_next)
    );

    always_comb begin
        res_d       = res_q;
        res_d.valid = in_valid;
        if (in_valid) begin
            res_d.taken   = c_taken;
            res_d.is_br   = c_isbr;
            res_d.target  = c_target;
            res_d.next_pc = c_next;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign res_valid  = res_q.valid;
    assign taken      = res_q.taken;
    assign is_branch  = res_q.is_br;
    assign not_branch = ~res_q.is_br;
    assign target     = res_q.target;
    assign next_pc    = res_q.next_pc;

    // R8
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(next_pc) && $stable(taken) && !res_valid));

    // R8
    valid_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> res_valid);

    // R5
    next_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> (next_pc == target));

    // R1
    nonbranch_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        not_branch |-> !taken);

    // R6
    next_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        next_pc[0] == 1'b0);
endmodule

// File: tb/tb_cbr_unit.sv
`timescale 1ns/1ps
module tb_cbr_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] instr = '0;
    logic [15:0] seq_pc = '0;
    logic        fn = 0, fz = 0, fc = 0, fv = 0;
    logic        res_valid, taken, is_branch, not_branch;
    logic [15:0] target, next_pc;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2 clk = ~clk;

    cbr_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .seq_pc(seq_pc), .flag_n(fn), .flag_z(fz), .flag_c(fc), .flag_v(fv),
        .res_valid(res_valid), .taken(taken), .is_branch(is_branch),
        .not_branch(not_branch), .target(target), .next_pc(next_pc)
    );

    function automatic bit exp_pass(input logic [2:0] c, input logic n, z, cy, v);
        case (c)
            3'd0: return !z;
            3'd1: return z;
            3'd2: return !cy;
            3'd3: return cy;
            3'd4: return n;
            3'd5: return n == v;
            3'd6: return n != v;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [15:0] exp_tgt(input logic [15:0] pc, input logic [9:0] o);
        int s;
        s = $signed(o);
        return 16'((int'({pc[15:1], 1'b0})) + 2 * s);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [15:0] w, input logic [15:0] pc,
                         input logic [3:0] f, input string req);
        logic isb, tk;
        logic [15:0] tg, np;
        @(negedge clk);
        instr = w; seq_pc = pc; {fn, fz, fc, fv} = f; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        isb = (w[15:13] == 3'b001);
        tk  = isb && exp_pass(w[12:10], f[3], f[2], f[1], f[0]);
        tg  = exp_tgt(pc, w[9:0]);
        np  = tk ? tg : {pc[15:1], 1'b0};
        chk({req, " valid R8"}, 32'(res_valid), 32'd1);
        chk({req, " taken"}, 32'(taken), 32'(tk));
        chk({req, " is_branch R1"}, 32'({is_branch, not_branch}), 32'({isb, !isb}));
        if (isb) chk({req, " target R4"}, 32'(target), 32'(tg));
        chk({req, " next_pc R5"}, 32'(next_pc), 32'(np));
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] held;
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        // R9
        chk("R9 reset valid", 32'(res_valid), 0);
        chk("R9 reset taken", 32'(taken), 0);
        chk("R9 reset not_branch", 32'({is_branch, not_branch}), 32'b01);
        chk("R9 reset next_pc", 32'(next_pc), 0);
        rst_n = 1'b1;
        // R2 R3 all conditions x all flags
        for (int c = 0; c < 8; c++)
            for (int f = 0; f < 16; f++)
                apply({3'b001, 3'(c), 10'h015}, 16'h4000, 4'(f), c < 4 ? "R2" : "R3");
        // R7
        apply(16'h2FE4, 16'h1000, 4'b0010, "R7 set");
        chk("R7 target", 32'(next_pc), 32'(16'h1000 - 16'd56));
        apply(16'h2FE4, 16'h1000, 4'b0000, "R7 clear");
        chk("R7 not taken", 32'(taken), 0);
        // R4 offset extremes and wraparound
        apply(16'h3C00, 16'h0100, 4'b0, "R4 zero");
        apply(16'h3DFF, 16'hFF00, 4'b0, "R4 max");
        apply(16'h3E00, 16'h0010, 4'b0, "R4 min");
        // R6 odd seq_pc
        apply(16'h3C05, 16'h2001, 4'b0, "R6 odd");
        chk("R6 next even", 32'(next_pc[0]), 0);
        apply(16'h2000, 16'h2001, 4'b0100, "R6 fall odd");
        chk("R6 fall even", 32'(next_pc[0]), 0);
        // R1 non-branch words
        for (int i = 0; i < 40; i++) begin
            logic [15:0] w;
            w = 16'($urandom);
            if (w[15:13] == 3'b001) w[15] = 1'b1;
            apply(w, 16'($urandom) & 16'hFFFE, 4'($urandom), "R1 nonbr");
        end
        // random mix
        for (int i = 0; i < 300; i++)
            apply(16'($urandom), 16'($urandom), 4'($urandom), "R5 rand");
        // R8 hold
        held = next_pc;
        @(negedge clk);
        instr = 16'h3C10; seq_pc = 16'h8888;
        @(negedge clk);
        chk("R8 idle valid", 32'(res_valid), 0);
        chk("R8 idle hold", 32'(next_pc), 32'(held));
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule